// File: doc/BRIEF.md
# Repeating Memory-to-Port Byte Streamer

This block moves a run of bytes from memory out to an I/O port with no help from the processor core. A start strobe loads three registers: a byte count, a source pointer into memory and a port pointer. For each byte, the block reads memory at the source pointer. It then writes that byte to a port address built from the low part of the port pointer. After the write, the count and both pointers each step down by one. The run ends when the count reaches zero.

A mode input picks how wide the registers are: a narrow width (16 bits by default) or the full 24 bits. In narrow mode the loaded values lose their upper bits, and every decrement wraps within the narrow width. The memory read port has one cycle of latency, which suits an inferred block RAM.

A flag byte comes in at start. It goes out again with two fields rewritten after every byte: a zero flag that reports whether the count has just run out, and a sign-copy flag that holds bit 7 of the byte just sent. A length-override input adds one set-up cycle to the run, which matches the timing of an instruction that carries a width-override prefix.

Top module: `bout_seq`

## Requirements
- R1: When the block is idle, a `start` pulse loads the count, source pointer, port pointer, flag byte and width mode, and `busy` rises on the next cycle. A `start` pulse while `busy` is high has no effect on the run in progress.
- R2: Each byte takes exactly three cycles. In the first, `mem_rd` is high with `mem_addr` set to the source pointer. In the second, nothing is strobed while the read data returns. In the third, `io_wr` is high for that one cycle and `io_wdata` carries the byte that was read.
- R3: During a port write, `io_addr` holds zero above bit 15, and its bits 15:0 hold bits 15:0 of the port pointer.
- R4: After every byte, the count, the source pointer and the port pointer each drop by one, modulo 2^W. W is the active width.
- R5: The run stops after the byte that takes the count to zero. A loaded count of zero wraps, so the run moves 2^W bytes.
- R6: After each byte, flag bit 6 (Z) is 1 if the decremented count is zero and 0 otherwise.
- R7: After each byte, flag bit 1 (N) equals bit 7 of the byte just written. All other flag bits keep the values loaded at start.
- R8: `busy` stays high for 2 + 3·count cycles, or 3 + 3·count cycles when `len_pfx` is set at start. `done` is high for exactly the last of those cycles.
- R9: After reset, `busy`, `done`, `mem_rd` and `io_wr` are low and `flags_out` is zero.
- R10: In narrow mode, the loaded count and pointers keep only their low W bits, so `mem_addr` is zero above the narrow width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| wide_mode | input | 1 | 1 selects 24-bit registers, 0 selects the narrow width |
| len_pfx | input | 1 | Adds one set-up cycle |
| cnt_in | input | 24 | Byte count to load |
| io_ptr_in | input | 24 | Port pointer to load |
| src_ptr_in | input | 24 | Memory source pointer to load |
| flags_in | input | 8 | Flag byte to load |
| busy | output | 1 | Run in progress |
| done | output | 1 | High in the final busy cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| io_wr | output | 1 | Port write strobe |
| io_addr | output | 24 | Port write address |
| io_wdata | output | 8 | Port write data |
| flags_out | output | 8 | Flag byte with Z and N updated |

## Verification
The runs vary the source memory so that the sign bit of the data changes from byte to byte, which separates N tracking from a stale or constant N. A single-byte run with the override set, and a longer run without it, separate the two set-up lengths and the exact point where Z becomes 1. Narrow-mode runs load pointers near zero with their upper bits set. These runs show whether the width mask is applied on load and whether decrements wrap within the narrow width. A zero count in narrow mode confirms the full-range wrap. A `start` pulse fired part way through a run shows that it has no effect.

// File: rtl/bout_pkg.sv
package bout_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_LATCH,
    ST_WRITE,
    ST_FIN
  } bout_state_e;

  localparam int FLG_Z_BIT = 6;
  localparam int FLG_N_BIT = 1;
endpackage

// File: rtl/bout_ptr_bank.sv
module bout_ptr_bank #(
  parameter int REG_W    = 24,
  parameter int NARROW_W = 16,
  parameter int NPTR     = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  dec,
  input  logic                  wide_in,
  input  logic [NPTR*REG_W-1:0] ld_vals,
  output logic [NPTR*REG_W-1:0] vals,
  output logic                  wide_q
);
  localparam logic [REG_W-1:0] NMASK = {{(REG_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [REG_W-1:0] WMASK = '1;

  logic [REG_W-1:0] ld_mask;
  logic [REG_W-1:0] run_mask;

  assign ld_mask  = wide_in ? WMASK : NMASK;
  assign run_mask = wide_q  ? WMASK : NMASK;

  always_ff @(posedge clk) begin
    if (rst)       wide_q <= 1'b0;
    else if (load) wide_q <= wide_in;
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [REG_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)       val_q <= '0;
      else if (load) val_q <= ld_vals[g*REG_W +: REG_W] & ld_mask;
      else if (dec)  val_q <= (val_q - REG_W'(1)) & run_mask;
    end
    assign vals[g*REG_W +: REG_W] = val_q;

    // R10: in narrow mode nothing survives above the narrow width
    a_r10_narrow_upper: assert property (@(posedge clk) disable iff (rst)
      !wide_q |-> (val_q & ~NMASK) == '0);
  end
endmodule

// File: rtl/bout_ctrl.sv
module bout_ctrl
  import bout_pkg::*;
#(
  parameter int BASE_SETUP = 1,
  parameter int PFX_EXTRA  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        len_pfx,
  input  logic        cnt_is_one,
  output bout_state_e state,
  output logic        load,
  output logic        dec,
  output logic        latch
);
  localparam int SETUP_MAX = BASE_SETUP + PFX_EXTRA;
  localparam int SETUP_W   = (SETUP_MAX < 2) ? 1 : $clog2(SETUP_MAX + 1);

  logic [SETUP_W-1:0] setup_cnt;

  assign load  = (state == ST_IDLE) && start;
  assign dec   = (state == ST_WRITE);
  assign latch = (state == ST_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      setup_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_SETUP;
          setup_cnt <= SETUP_W'(BASE_SETUP - 1) + (len_pfx ? SETUP_W'(PFX_EXTRA) : '0);
        end
        ST_SETUP: begin
          if (setup_cnt == '0) state <= ST_READ;
          else                 setup_cnt <= setup_cnt - SETUP_W'(1);
        end
        ST_READ:  state <= ST_LATCH;
        ST_LATCH: state <= ST_WRITE;
        ST_WRITE: state <= cnt_is_one ? ST_FIN : ST_READ;
        ST_FIN:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  a_r2_read_to_latch: assert property (@(posedge clk) disable iff (rst)
    state == ST_READ |=> state == ST_LATCH);
  a_r2_latch_to_write: assert property (@(posedge clk) disable iff (rst)
    state == ST_LATCH |=> state == ST_WRITE);
  a_r8_fin_to_idle: assert property (@(posedge clk) disable iff (rst)
    state == ST_FIN |=> state == ST_IDLE);
  a_r1_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && state != ST_FIN) |=> state != ST_IDLE);
endmodule

// File: rtl/bout_flags.sv
module bout_flags
  import bout_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic              upd,
  input  logic              last,
  input  logic              msb,
  output logic [FLAG_W-1:0] flags_q
);
  localparam logic [FLAG_W-1:0] KEEP = ~((FLAG_W'(1) << FLG_Z_BIT) | (FLAG_W'(1) << FLG_N_BIT));

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else if (load) flags_q <= flags_in;
    else if (upd) begin
      flags_q[FLG_Z_BIT] <= last;
      flags_q[FLG_N_BIT] <= msb;
    end
  end

  a_r7_n_copies_msb: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags_q[FLG_N_BIT] == $past(msb));
  a_r7_others_kept: assert property (@(posedge clk) disable iff (rst)
    upd |=> (flags_q & KEEP) == $past(flags_q & KEEP));
  a_r6_z_follows_last: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags_q[FLG_Z_BIT] == $past(last));
endmodule

// File: rtl/bout_seq.sv
module bout_seq
  import bout_pkg::*;
#(
  parameter int REG_W      = 24,
  parameter int NARROW_W   = 16,
  parameter int IO_LO_W    = 16,
  parameter int DATA_W     = 8,
  parameter int FLAG_W     = 8,
  parameter int BASE_SETUP = 1,
  parameter int PFX_EXTRA  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wide_mode,
  input  logic              len_pfx,
  input  logic [REG_W-1:0]  cnt_in,
  input  logic [REG_W-1:0]  io_ptr_in,
  input  logic [REG_W-1:0]  src_ptr_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              busy,
  output logic              done,
  output logic              mem_rd,
  output logic [REG_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              io_wr,
  output logic [REG_W-1:0]  io_addr,
  output logic [DATA_W-1:0] io_wdata,
  output logic [FLAG_W-1:0] flags_out
);
  localparam int NPTR    = 3;
  localparam int SL_CNT  = 0;
  localparam int SL_IO   = 1;
  localparam int SL_SRC  = 2;

  bout_state_e             state;
  logic                    load, dec, latch, wide_q;
  logic [NPTR*REG_W-1:0]   ld_vals, vals;
  logic [REG_W-1:0]        cnt_q, io_q, src_q;
  logic                    cnt_is_one;
  logic [DATA_W-1:0]       data_q;

  assign ld_vals[SL_CNT*REG_W +: REG_W] = cnt_in;
  assign ld_vals[SL_IO*REG_W  +: REG_W] = io_ptr_in;
  assign ld_vals[SL_SRC*REG_W +: REG_W] = src_ptr_in;
  assign cnt_q = vals[SL_CNT*REG_W +: REG_W];
  assign io_q  = vals[SL_IO*REG_W  +: REG_W];
  assign src_q = vals[SL_SRC*REG_W +: REG_W];
  assign cnt_is_one = (cnt_q == REG_W'(1));

  bout_ctrl #(.BASE_SETUP(BASE_SETUP), .PFX_EXTRA(PFX_EXTRA)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .len_pfx(len_pfx),
    .cnt_is_one(cnt_is_one), .state(state), .load(load), .dec(dec), .latch(latch)
  );

  bout_ptr_bank #(.REG_W(REG_W), .NARROW_W(NARROW_W), .NPTR(NPTR)) u_bank (
    .clk(clk), .rst(rst), .load(load), .dec(dec), .wide_in(wide_mode),
    .ld_vals(ld_vals), .vals(vals), .wide_q(wide_q)
  );

  bout_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst(rst), .load(load), .flags_in(flags_in),
    .upd(dec), .last(cnt_is_one), .msb(data_q[DATA_W-1]), .flags_q(flags_out)
  );

  always_ff @(posedge clk) begin
    if (rst)        data_q <= '0;
    else if (latch) data_q <= mem_rdata;
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign mem_rd   = (state == ST_READ);
  assign mem_addr = src_q;
  assign io_wr    = (state == ST_WRITE);
  assign io_addr  = {{(REG_W-IO_LO_W){1'b0}}, io_q[IO_LO_W-1:0]};
  assign io_wdata = data_q;

  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    io_wr |-> $past(mem_rd, 2));
  a_r3_io_upper_zero: assert property (@(posedge clk) disable iff (rst)
    io_wr |-> io_addr[REG_W-1:IO_LO_W] == '0);
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, io_wr, done}));
  a_r5_last_ends: assert property (@(posedge clk) disable iff (rst)
    (io_wr && cnt_is_one) |=> done);
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);
  a_r1_start_takes: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/bout_seq_tb.sv
module bout_seq_tb;
  localparam int CLK_P = 10;
  localparam int NW    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, wide_mode = 1'b0, len_pfx = 1'b0;
  logic [23:0] cnt_in = '0, io_ptr_in = '0, src_ptr_in = '0;
  logic [7:0]  flags_in = '0;
  logic        busy, done, mem_rd, io_wr;
  logic [23:0] mem_addr, io_addr;
  logic [7:0]  mem_rdata = '0, io_wdata, flags_out;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #(CLK_P/2) clk = ~clk;

  bout_seq #(.NARROW_W(NW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .wide_mode(wide_mode), .len_pfx(len_pfx),
    .cnt_in(cnt_in), .io_ptr_in(io_ptr_in), .src_ptr_in(src_ptr_in), .flags_in(flags_in),
    .busy(busy), .done(done), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata), .flags_out(flags_out)
  );

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= fmem(mem_addr);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  logic [7:0] last_flags = '0;

  task automatic run_op(input bit wide, input bit pfx, input logic [23:0] c,
                        input logic [23:0] io, input logic [23:0] src,
                        input logic [7:0] fl, input bit poke);
    logic [23:0] mask;
    int s, n, tot;
    logic [23:0] c0, io0, src0;
    mask = wide ? 24'hFFFFFF : 24'((1 << NW) - 1);
    c0 = c & mask; io0 = io & mask; src0 = src & mask;
    n = (c0 == 0) ? int'(mask) + 1 : int'(c0);
    s = pfx ? 2 : 1;
    tot = s + 3 * n + 1;
    @(negedge clk);
    wide_mode = wide; len_pfx = pfx; cnt_in = c; io_ptr_in = io;
    src_ptr_in = src; flags_in = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= tot + 1; k++) begin
      int b, j, p;
      logic [7:0] ef;
      bit erd, ewr;
      erd = 0; ewr = 0; j = 0; p = 0;
      if (k > s && k <= s + 3 * n) begin
        j = (k - s - 1) / 3; p = (k - s - 1) % 3;
        erd = (p == 0); ewr = (p == 2);
      end
      b = (k <= s + 3) ? 0 : (k - s - 1) / 3;
      if (b > n) b = n;
      ef = fl;
      if (b > 0) begin
        ef[6] = (((c0 - 24'(b)) & mask) == 0);
        ef[1] = fmem((src0 - 24'(b - 1)) & mask)[7];
      end
      chk("R8 busy", busy, k <= tot);
      chk("R8 done", done, k == tot);
      chk("R2 mem_rd", mem_rd, erd);
      chk("R2 io_wr", io_wr, ewr);
      chk("R6/R7 flags", flags_out, ef);
      if (erd) chk("R4/R10 mem_addr", mem_addr, (src0 - 24'(j)) & mask);
      if (ewr) begin
        chk("R3/R4 io_addr", io_addr, {8'h00, 16'((io0 - 24'(j)) & mask)});
        chk("R2 io_wdata", io_wdata, fmem((src0 - 24'(j)) & mask));
      end
      last_flags = ef;
      if (poke && k == 4) begin
        // R1: start while busy must not disturb the run
        start = 1'b1; cnt_in = 24'h7; src_ptr_in = 24'h55; io_ptr_in = 24'h66;
        flags_in = 8'h00; len_pfx = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", busy, 0); chk("R9 done", done, 0);
    chk("R9 mem_rd", mem_rd, 0); chk("R9 io_wr", io_wr, 0);
    chk("R9 flags", flags_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle", busy, 0);
    run_op(1, 0, 24'd4, 24'h123456, 24'h000102, 8'hA5, 0);      // R3 upper bits dropped
    run_op(1, 1, 24'd1, 24'h00ABCD, 24'h004321, 8'h00, 0);      // R8 prefix timing, R6 single
    run_op(0, 0, 24'hFF0003, 24'hFF0000, 24'hAB0001, 8'hFF, 1); // R10 mask, R4 wrap, R1 poke
    run_op(1, 0, 24'd2, 24'h000000, 24'h000000, 8'h5A, 0);      // R4 wide wrap
    run_op(0, 1, 24'h000000, 24'h000080, 24'h000010, 8'h42, 0); // R5 zero count wraps
    chk("R5 idle after run", busy, 0);
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog R8 got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule